// File: doc/BRIEF.md
# Job Ring Index and Status Manager

This block holds the control state for two circular rings that software shares with a processing engine. The submit ring carries jobs from software to the engine. The completion ring carries results back to software. Software programs the size of each ring. It tells the block how many jobs it has placed in the submit ring and how many completions it has taken out of the completion ring. The engine is modelled by two strobes: `eng_take` (one job taken from the submit ring) and `eng_put` (one completion written to the completion ring).

The block tracks the free room of the submit ring and its read index. It also tracks the number of full slots in the completion ring and its write index. A report that would push a ring past its bounds is refused and recorded with an error code and a captured index. Completions raise an interrupt, either one per completion or coalesced by a count threshold and a timeout. A reset command clears the ring state and reports a two-step halt status. All registers sit behind a simple word-wide write and read port.

Top module: `jring_mgr`

## Requirements
- R1: After reset every readable register returns zero and `irq` is low.
- R2: Writing a ring size (address 0 submit, 3 completion) keeps only the low RING_W bits of the data. The submit room is reloaded to the size. The completion full-count and both indices become zero.
- R3: Writing n to address 1 reduces the submit room by n. Each `eng_take` pulse taken while room < size adds one to the room and advances the submit read index (address 2) by one, wrapping from size-1 to 0. A pulse taken while room = size changes nothing.
- R4: Each `eng_put` pulse taken while full-count < size adds one to the full-count (address 4 read) and advances the completion write index (address 5), wrapping at the size. A pulse taken at full-count = size changes nothing. Writing n to address 4 reduces the full-count by n.
- R5: A submit report n greater than the room leaves the room unchanged. It sets status bit 1 (error), sets code 9 in status bits 11:8, and copies the submit read index into status bits 29:16. It also sets status bit 0.
- R6: A completion removal n greater than the full-count leaves the full-count unchanged. It sets status bit 1, code 8 in bits 11:8, and copies the completion write index into bits 29:16. It also sets status bit 0.
- R7: With coalescing off, every accepted `eng_put` sets status bit 0. Writing a 1 to status bit 0 clears it. Writing a 1 to status bit 1 clears the error bit, the code and the captured index.
- R8: `irq` equals status bit 0 while configuration bit 0 (mask) is clear, and is low while the mask is set.
- R9: With configuration bit 1 set, status bit 0 is set when pending completions reach the threshold in configuration bits 23:16 (0 acts as 1). It is also set when the timeout in bits 15:8 (0 disables it) has elapsed, counted in clocks from the first pending completion.
- R10: With configuration bit 2 set and status bit 1 set, `eng_take` and `eng_put` are ignored.
- R11: Writing bit 0 of address 8 clears both indices, the full-count and the status bits, and reloads the room to the size. Status bits 3:2 read 01 for one cycle, during which engine strobes and count reports are ignored. They then read 10 until a 1 is written to status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| eng_take | input | 1 | Engine takes one job from the submit ring |
| eng_put | input | 1 | Engine writes one completion entry |
| irq | output | 1 | Masked ring interrupt |

## Verification
Assertions check on every cycle that neither ring level exceeds its size and that both indices stay inside the ring. They also check that a refused report never lowers a level, that the error code is always 8 or 9 while the error bit is set, that a new error always raises the interrupt bit, and that the first halt phase lasts exactly one cycle. Only the bench scenarios show the arithmetic: index wrap across a sweep of ring sizes, the exact captured error index, coalescing by threshold and by timeout, masking, stop on error and the full reset-command sequence.

// File: rtl/jring_pkg.sv
package jring_pkg;
  localparam int ERR_IDX_W = 14;

  typedef enum logic [3:0] {
    A_SUB_SIZE = 4'd0,
    A_SUB_ADD  = 4'd1,
    A_SUB_IDX  = 4'd2,
    A_CPL_SIZE = 4'd3,
    A_CPL_REM  = 4'd4,
    A_CPL_IDX  = 4'd5,
    A_STATUS   = 4'd6,
    A_CONFIG   = 4'd7,
    A_COMMAND  = 4'd8
  } reg_addr_e;

  localparam logic [3:0] ERR_REMOVE_OVF = 4'd8;
  localparam logic [3:0] ERR_ADD_OVF    = 4'd9;

  typedef enum logic [1:0] {
    H_IDLE = 2'd0,
    H_PROG = 2'd1,
    H_DONE = 2'd2
  } halt_e;
endpackage

// File: rtl/jring_ctr.sv
module jring_ctr #(
  parameter int RING_W    = 10,
  parameter bit LOAD_FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RING_W-1:0] load_size,
  input  logic [RING_W-1:0] size,
  input  logic              run,
  input  logic              sw_vld,
  input  logic [RING_W:0]   sw_n,
  input  logic              hw_evt,
  output logic [RING_W-1:0] level,
  output logic [RING_W-1:0] idx,
  output logic              sw_ovf,
  output logic              hw_ok
);
  logic [RING_W-1:0] reload;
  logic [RING_W-1:0] level_d, idx_d, sub_n;

  generate
    if (LOAD_FULL) begin : g_full
      assign reload = load_size;
    end else begin : g_empty
      assign reload = '0;
    end
  endgenerate

  assign sw_ovf = sw_vld && (sw_n > {1'b0, level});
  assign hw_ok  = run && hw_evt && (level < size);
  assign sub_n  = (sw_vld && !sw_ovf) ? sw_n[RING_W-1:0] : '0;

  always_comb begin
    level_d = level;
    idx_d   = idx;
    if (load) begin
      level_d = reload;
      idx_d   = '0;
    end else begin
      level_d = level - sub_n + {{(RING_W-1){1'b0}}, hw_ok};
      if (hw_ok) idx_d = (idx == size - 1'b1) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      idx   <= '0;
    end else begin
      level <= level_d;
      idx   <= idx_d;
    end
  end

  // R3 R4
  level_le_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= size);
  // R3 R4
  idx_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size == '0) ? (idx == '0) : (idx < size));
  // R5 R6
  ovf_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ovf && !load) |=> (level >= $past(level)));
endmodule

// File: rtl/jring_status.sv
module jring_status
  import jring_pkg::*;
#(
  parameter int RING_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rst_cmd,
  input  logic                 add_ovf,
  input  logic [RING_W-1:0]    add_idx,
  input  logic                 rm_ovf,
  input  logic [RING_W-1:0]    rm_idx,
  input  logic                 put_ok,
  input  logic                 w1c_vld,
  input  logic [31:0]          w1c_data,
  input  logic                 coal_en,
  input  logic                 stop_err,
  input  logic [7:0]           coal_thr,
  input  logic [7:0]           coal_tmo,
  output logic                 int_bit,
  output logic                 err_bit,
  output logic [3:0]           err_type,
  output logic [ERR_IDX_W-1:0] err_idx,
  output halt_e                halt,
  output logic                 eng_run
);
  logic                 int_d, err_d;
  logic [3:0]           type_d;
  logic [ERR_IDX_W-1:0] eidx_d;
  halt_e                halt_d;
  logic [7:0]           pend, pend_d, tmr, tmr_d, thr_eff;
  logic [8:0]           pend_n;
  logic                 fire;

  assign eng_run = (halt != H_PROG) && !(stop_err && err_bit);
  assign thr_eff = (coal_thr == 8'd0) ? 8'd1 : coal_thr;
  assign pend_n  = {1'b0, pend} + {8'd0, put_ok};

  always_comb begin
    fire = 1'b0;
    if (!coal_en) fire = put_ok;
    else if (put_ok && pend_n >= {1'b0, thr_eff}) fire = 1'b1;
    else if (pend != 8'd0 && coal_tmo != 8'd0 &&
             ({1'b0, tmr} + 9'd1) >= {1'b0, coal_tmo}) fire = 1'b1;
  end

  always_comb begin
    int_d  = int_bit;
    err_d  = err_bit;
    type_d = err_type;
    eidx_d = err_idx;
    halt_d = halt;
    pend_d = pend;
    tmr_d  = tmr;
    if (w1c_vld && w1c_data[0]) int_d = 1'b0;
    if (w1c_vld && w1c_data[1]) begin
      err_d  = 1'b0;
      type_d = 4'd0;
      eidx_d = '0;
    end
    if (w1c_vld && w1c_data[3] && halt == H_DONE) halt_d = H_IDLE;
    if (halt == H_PROG) halt_d = H_DONE;
    if (coal_en) begin
      pend_d = (pend_n > 9'd255) ? 8'd255 : pend_n[7:0];
      tmr_d  = (pend == 8'd0) ? 8'd0 : tmr + 8'd1;
    end
    if (fire) begin
      int_d  = 1'b1;
      pend_d = 8'd0;
      tmr_d  = 8'd0;
    end
    if (add_ovf) begin
      err_d  = 1'b1;
      type_d = ERR_ADD_OVF;
      eidx_d = ERR_IDX_W'(add_idx);
      int_d  = 1'b1;
    end else if (rm_ovf) begin
      err_d  = 1'b1;
      type_d = ERR_REMOVE_OVF;
      eidx_d = ERR_IDX_W'(rm_idx);
      int_d  = 1'b1;
    end
    if (rst_cmd) begin
      int_d  = 1'b0;
      err_d  = 1'b0;
      type_d = 4'd0;
      eidx_d = '0;
      pend_d = 8'd0;
      tmr_d  = 8'd0;
      halt_d = H_PROG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_bit  <= 1'b0;
      err_bit  <= 1'b0;
      err_type <= 4'd0;
      err_idx  <= '0;
      halt     <= H_IDLE;
      pend     <= 8'd0;
      tmr      <= 8'd0;
    end else begin
      int_bit  <= int_d;
      err_bit  <= err_d;
      err_type <= type_d;
      err_idx  <= eidx_d;
      halt     <= halt_d;
      pend     <= pend_d;
      tmr      <= tmr_d;
    end
  end

  // R5 R6
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_bit |-> (err_type == ERR_ADD_OVF || err_type == ERR_REMOVE_OVF));
  // R5 R6
  err_raises_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_bit) |-> int_bit);
  // R11
  halt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt == H_PROG && !rst_cmd) |=> (halt == H_DONE));
endmodule

// File: rtl/jring_mgr.sv
module jring_mgr
  import jring_pkg::*;
#(
  parameter int RING_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              eng_take,
  input  logic              eng_put,
  output logic              irq
);
  logic [1:0]           rst_sync;
  logic                 rst_ni;
  logic [RING_W-1:0]    sub_size, cpl_size, sub_size_d, cpl_size_d;
  logic                 cfg_mask, cfg_coal, cfg_soe;
  logic [7:0]           cfg_tmo, cfg_thr;
  logic                 wr_sub_sz, wr_cpl_sz, wr_add, wr_rem, wr_stat, wr_cfg, rst_cmd;
  logic [RING_W-1:0]    room, sub_idx, full, cpl_idx;
  logic                 add_ovf, rm_ovf, take_ok, put_ok, eng_run, halt_prog;
  logic                 int_bit, err_bit;
  logic [3:0]           err_type;
  logic [ERR_IDX_W-1:0] err_idx;
  halt_e                halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign wr_sub_sz = wr_en && (wr_addr == ADDR_W'(A_SUB_SIZE));
  assign wr_cpl_sz = wr_en && (wr_addr == ADDR_W'(A_CPL_SIZE));
  assign wr_add    = wr_en && (wr_addr == ADDR_W'(A_SUB_ADD)) && !halt_prog;
  assign wr_rem    = wr_en && (wr_addr == ADDR_W'(A_CPL_REM)) && !halt_prog;
  assign wr_stat   = wr_en && (wr_addr == ADDR_W'(A_STATUS));
  assign wr_cfg    = wr_en && (wr_addr == ADDR_W'(A_CONFIG));
  assign rst_cmd   = wr_en && (wr_addr == ADDR_W'(A_COMMAND)) && wr_data[0];
  assign halt_prog = (halt == H_PROG);

  assign sub_size_d = wr_sub_sz ? wr_data[RING_W-1:0] : sub_size;
  assign cpl_size_d = wr_cpl_sz ? wr_data[RING_W-1:0] : cpl_size;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_size <= '0;
      cpl_size <= '0;
      cfg_mask <= 1'b0;
      cfg_coal <= 1'b0;
      cfg_soe  <= 1'b0;
      cfg_tmo  <= 8'd0;
      cfg_thr  <= 8'd0;
    end else begin
      sub_size <= sub_size_d;
      cpl_size <= cpl_size_d;
      if (wr_cfg) begin
        cfg_mask <= wr_data[0];
        cfg_coal <= wr_data[1];
        cfg_soe  <= wr_data[2];
        cfg_tmo  <= wr_data[15:8];
        cfg_thr  <= wr_data[23:16];
      end
    end
  end

  jring_ctr #(.RING_W(RING_W), .LOAD_FULL(1'b1)) u_sub (
    .clk(clk), .rst_n(rst_ni),
    .load(wr_sub_sz || rst_cmd), .load_size(sub_size_d), .size(sub_size),
    .run(eng_run), .sw_vld(wr_add), .sw_n(wr_data[RING_W:0]),
    .hw_evt(eng_take), .level(room), .idx(sub_idx),
    .sw_ovf(add_ovf), .hw_ok(take_ok)
  );

  jring_ctr #(.RING_W(RING_W), .LOAD_FULL(1'b0)) u_cpl (
    .clk(clk), .rst_n(rst_ni),
    .load(wr_cpl_sz || rst_cmd), .load_size(cpl_size_d), .size(cpl_size),
    .run(eng_run), .sw_vld(wr_rem), .sw_n(wr_data[RING_W:0]),
    .hw_evt(eng_put), .level(full), .idx(cpl_idx),
    .sw_ovf(rm_ovf), .hw_ok(put_ok)
  );

  jring_status #(.RING_W(RING_W)) u_stat (
    .clk(clk), .rst_n(rst_ni), .rst_cmd(rst_cmd),
    .add_ovf(add_ovf), .add_idx(sub_idx), .rm_ovf(rm_ovf), .rm_idx(cpl_idx),
    .put_ok(put_ok), .w1c_vld(wr_stat), .w1c_data(wr_data),
    .coal_en(cfg_coal), .stop_err(cfg_soe), .coal_thr(cfg_thr), .coal_tmo(cfg_tmo),
    .int_bit(int_bit), .err_bit(err_bit), .err_type(err_type), .err_idx(err_idx),
    .halt(halt), .eng_run(eng_run)
  );

  always_comb begin
    rd_data = 32'd0;
    case (rd_addr)
      ADDR_W'(A_SUB_SIZE): rd_data = 32'(sub_size);
      ADDR_W'(A_SUB_ADD):  rd_data = 32'(room);
      ADDR_W'(A_SUB_IDX):  rd_data = 32'(sub_idx);
      ADDR_W'(A_CPL_SIZE): rd_data = 32'(cpl_size);
      ADDR_W'(A_CPL_REM):  rd_data = 32'(full);
      ADDR_W'(A_CPL_IDX):  rd_data = 32'(cpl_idx);
      ADDR_W'(A_STATUS):   rd_data = {2'b00, err_idx, 4'd0, err_type, 4'd0,
                                      halt, err_bit, int_bit};
      ADDR_W'(A_CONFIG):   rd_data = {8'd0, cfg_thr, cfg_tmo, 5'd0,
                                      cfg_soe, cfg_coal, cfg_mask};
      default:             rd_data = 32'd0;
    endcase
  end

  assign irq = int_bit && !cfg_mask;

  // R10
  soe_blocks_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_soe && err_bit) |-> !(take_ok || put_ok));
  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    halt_prog |=> (sub_idx == $past(sub_idx) && full == $past(full)));
endmodule

// File: tb/tb_jring_mgr.sv
module tb_jring_mgr;
  localparam int RW = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        eng_take = 1'b0;
  logic        eng_put = 1'b0;
  logic        irq;
  int          errors = 0;
  int          checks = 0;

  jring_mgr #(.RING_W(RW), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_take(eng_take), .eng_put(eng_put), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); eng_take = 1'b1;
    @(negedge clk); eng_take = 1'b0;
  endtask

  task automatic put();
    @(negedge clk); eng_put = 1'b1;
    @(negedge clk); eng_put = 1'b0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 8; a++) chk_reg("R1 reg after reset", 4'(a), 32'd0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);

    // R2 size field width
    wr(4'd0, 32'h1F);
    chk_reg("R2 size masked", 4'd0, 32'd15);
    chk_reg("R2 room reload", 4'd1, 32'd15);

    // R3 submit ring sweep over sizes
    for (int s = 1; s <= 8; s++) begin
      wr(4'd0, 32'(s));
      chk_reg("R2 room equals size", 4'd1, 32'(s));
      chk_reg("R2 read index zero", 4'd2, 32'd0);
      wr(4'd1, 32'(s));
      chk_reg("R3 room after add", 4'd1, 32'd0);
      for (int k = 0; k <= s; k++) begin
        int n;
        n = (k + 1 < s) ? k + 1 : s;
        take();
        chk_reg("R3 read index", 4'd2, 32'(n % s));
        chk_reg("R3 room after take", 4'd1, 32'(n));
      end
    end

    // R4 R7 R8 completion ring sweep
    for (int s = 1; s <= 8; s++) begin
      wr(4'd3, 32'(s));
      wr(4'd6, 32'h1);
      chk_reg("R2 full count zero", 4'd4, 32'd0);
      for (int k = 0; k <= s; k++) begin
        int n;
        n = (k + 1 < s) ? k + 1 : s;
        put();
        chk_reg("R4 full count", 4'd4, 32'(n));
        chk_reg("R4 write index", 4'd5, 32'(n % s));
        chk_reg("R7 int bit per completion", 4'd6, (k < s) ? 32'h1 : 32'h0);
        chk("R8 irq follows int", {31'd0, irq}, (k < s) ? 32'd1 : 32'd0);
        wr(4'd6, 32'h1);
        chk_reg("R7 int cleared by w1c", 4'd6, 32'h0);
      end
      wr(4'd4, 32'(s));
      chk_reg("R4 full after remove", 4'd4, 32'd0);
    end

    // R8 mask
    wr(4'd7, 32'h1);
    wr(4'd3, 32'd4);
    put();
    chk_reg("R8 int set while masked", 4'd6, 32'h1);
    chk("R8 irq low while masked", {31'd0, irq}, 32'd0);
    wr(4'd7, 32'h0);
    chk("R8 irq after unmask", {31'd0, irq}, 32'd1);
    wr(4'd6, 32'h1);

    // R5 add overflow
    wr(4'd0, 32'd6);
    wr(4'd1, 32'd4);
    take();
    wr(4'd1, 32'd5);
    chk_reg("R5 room unchanged", 4'd1, 32'd3);
    chk_reg("R5 status code 9 index 1", 4'd6, 32'h0001_0903);
    wr(4'd6, 32'h3);
    chk_reg("R7 w1c clears error", 4'd6, 32'h0);

    // R6 remove overflow
    wr(4'd3, 32'd5);
    put(); put(); put();
    wr(4'd6, 32'h1);
    wr(4'd4, 32'd4);
    chk_reg("R6 full unchanged", 4'd4, 32'd3);
    chk_reg("R6 status code 8 index 3", 4'd6, 32'h0003_0803);

    // R10 stop on error, error still set
    wr(4'd7, 32'h4);
    put();
    chk_reg("R10 put ignored", 4'd4, 32'd3);
    take();
    chk_reg("R10 take ignored", 4'd2, 32'd1);
    wr(4'd6, 32'h3);
    put();
    chk_reg("R10 put after clear", 4'd4, 32'd4);
    wr(4'd7, 32'h0);

    // R9 coalescing by threshold
    wr(4'd3, 32'd8);
    wr(4'd7, 32'h0003_0002);
    wr(4'd6, 32'h1);
    put(); put();
    chk_reg("R9 below threshold", 4'd6, 32'h0);
    put();
    chk_reg("R9 threshold reached", 4'd6, 32'h1);
    // R9 coalescing by timeout
    wr(4'd7, 32'h000A_0502);
    wr(4'd6, 32'h1);
    put();
    repeat (4) @(negedge clk);
    chk_reg("R9 before timeout", 4'd6, 32'h0);
    @(negedge clk);
    chk_reg("R9 timeout fired", 4'd6, 32'h1);
    wr(4'd7, 32'h0);
    wr(4'd6, 32'h1);

    // R11 reset command
    wr(4'd0, 32'd6);
    wr(4'd1, 32'd3);
    take(); take();
    put(); put();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; eng_take = 1'b1; eng_put = 1'b1;
    chk_reg("R11 halt in progress", 4'd6, 32'h4);
    chk_reg("R11 room reloaded", 4'd1, 32'd6);
    chk_reg("R11 read index cleared", 4'd2, 32'd0);
    chk_reg("R11 full cleared", 4'd4, 32'd0);
    chk_reg("R11 write index cleared", 4'd5, 32'd0);
    @(negedge clk);
    eng_take = 1'b0; eng_put = 1'b0;
    chk_reg("R11 strobes ignored in halt", 4'd5, 32'd0);
    chk_reg("R11 halt complete", 4'd6, 32'h8);
    repeat (2) @(negedge clk);
    chk_reg("R11 halt complete sticky", 4'd6, 32'h8);
    wr(4'd6, 32'h8);
    chk_reg("R11 halt cleared", 4'd6, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule